// File: doc/BRIEF.md
# Burst Write Engine with Byte Packing Buffer

This block moves a byte stream from a disk-side source into system memory. Bytes come in on a valid/ready port and are joined in pairs into 16-bit words. The words are stored in an on-board buffer that is 64 words deep. The source side runs at its own pace and does not depend on who owns the system bus. When 32 words are waiting, the engine requests the bus. Once the bus is granted, it writes those 32 words back to back at ascending even addresses, then drops its request so that other masters can use the bus between bursts. When the last byte has arrived, any shorter remainder is written as one final burst.

Software starts a transfer with a single-cycle start pulse, a 24-bit start address and a byte length. The engine rejects a request whose end would pass the top of the 24-bit space. When all words have been written, the engine raises a completion flag. Grant latency can grow until the buffer is full and the source keeps waiting. When that wait reaches eight cycles, the engine sets an overrun flag and abandons the transfer so that software can retry it.

The controller has four states:
- ST_IDLE: waits for a start pulse. A start with a legal range moves the engine to ST_FILL.
- ST_FILL: collects words. It goes to ST_REQ at the threshold, or for the final flush. It returns to ST_IDLE when the word count reaches zero (completion) or on overrun (abort).
- ST_REQ: holds the request. It goes to ST_BURST on grant, or to ST_IDLE on overrun.
- ST_BURST: writes one word per cycle. It returns to ST_FILL after the last beat, or goes to ST_IDLE on overrun.

Top module: `burst_dma_engine`

## Requirements
- R1: While reset is held, and right after it is released, busy, done, err_overrun, err_range, bus_req, bus_wr and src_ready are all low, even if src_valid is high.
- R2: Each written word carries two consecutive stream bytes: the earlier byte in bits 7:0 and the later byte in bits 15:8. For an odd length, the last word holds the final byte in bits 7:0 and zero in bits 15:8.
- R3: bus_req rises only when the buffer holds at least 32 words, or when every byte of the transfer has been received.
- R4: After grant, bus_wr is high on consecutive cycles for exactly 32 beats. The exception is the last burst of a transfer, which carries the remaining words. The first address is the start address, and each following write is 2 higher. bus_req is low in the cycle after the last beat.
- R5: bus_req is never high while busy is low, and bus_wr is only high while bus_gnt is high.
- R6: src_ready is high while a transfer is active, bytes remain and the buffer is not full, whether or not the engine owns the bus. It is low while the buffer holds 64 words.
- R7: When src_valid stays high against a low src_ready for 8 consecutive cycles, err_overrun is set, busy drops and bus_req drops. A wait of 7 cycles followed by a pause sets nothing.
- R8: A start with address plus length greater than 2^24 sets err_range and begins no transfer. A start whose end lands exactly at 2^24 is accepted.
- R9: done rises and busy falls once ceil(length/2) words have been written.
- R10: A start pulse while busy is ignored. It does not change the address or length of the transfer in progress, and it sets no error flag.
- R11: An accepted start clears done, err_overrun and err_range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Single-cycle start pulse |
| cfg_addr | input | 24 | Byte address of the first word written |
| cfg_len | input | 16 | Transfer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished normally |
| err_overrun | output | 1 | Transfer abandoned because the source was blocked too long |
| err_range | output | 1 | Last start rejected because its range passes the top of the 24-bit space |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Engine takes the byte this cycle |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_wr | output | 1 | Write beat on the bus this cycle |
| bus_addr | output | 24 | Write address |
| bus_wdata | output | 16 | Write data |

## Verification
The bench sweeps transfer lengths around the pairing and burst boundaries: 1 to 4 bytes, 31, 63 to 66, 127 to 130, and 200. Each length runs with source gaps of 0, 1 and 3 idle cycles and with grant delays of 0, 2 and 7 cycles. Odd lengths separate correct zero padding from stale high bytes, and lengths just past 64 or 128 bytes separate a correct residual flush from a missing or oversized last burst. Varying the gap and the grant delay separates the threshold trigger from the end-of-input trigger. A never-granted bus brings out the full-buffer stall, tested at 7 and at 8 waiting cycles. Two range cases, one byte past 2^24 and exactly at 2^24, mark the acceptance boundary.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_REQ,
        ST_BURST
    } dma_state_e;

endpackage

// File: rtl/dma_byte_packer.sv
module dma_byte_packer #(
    parameter int LEN_W = 16,
    parameter int GRACE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             active,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             fifo_full,
    output logic             in_ready,
    output logic             push,
    output logic [15:0]      push_word,
    output logic             in_done,
    output logic             overrun
);

    localparam int SC_W = $clog2(GRACE + 1);
    localparam logic [SC_W-1:0] STALL_LAST = SC_W'(GRACE - 1);

    logic [LEN_W-1:0] bytes_left;
    logic [7:0]       hold_lo;
    logic             have_lo;
    logic [SC_W-1:0]  stall_cnt;
    logic             take;
    logic             last_byte;
    logic             stall;

    always_comb begin
        in_done   = (bytes_left == '0);
        in_ready  = active && !in_done && !fifo_full;
        take      = in_valid && in_ready;
        last_byte = (bytes_left == LEN_W'(1));
        push      = take && (have_lo || last_byte);
        push_word = have_lo ? {in_data, hold_lo} : {8'h00, in_data};
        stall     = active && !in_done && in_valid && fifo_full;
        overrun   = stall && (stall_cnt == STALL_LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_left <= '0;
            hold_lo    <= '0;
            have_lo    <= 1'b0;
            stall_cnt  <= '0;
        end else if (clear) begin
            bytes_left <= '0;
            have_lo    <= 1'b0;
            stall_cnt  <= '0;
        end else if (load) begin
            bytes_left <= load_len;
            have_lo    <= 1'b0;
            stall_cnt  <= '0;
        end else begin
            if (take) begin
                bytes_left <= bytes_left - LEN_W'(1);
                have_lo    <= !push;
                if (!push) begin
                    hold_lo <= in_data;
                end
            end
            stall_cnt <= stall ? stall_cnt + SC_W'(1) : '0;
        end
    end

    // R2
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !push) |=> have_lo);

    // R7
    stall_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cnt != '0) |-> $past(stall));

endmodule

// File: rtl/dma_word_fifo.sv
module dma_word_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         pop,
    output logic [WIDTH-1:0]             rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        rdata = mem[rd_ptr];
        full  = (count == CW'(DEPTH));
    end

    // R6
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH)));

    // R4
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int BURST  = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              in_done,
    input  logic              overrun,
    input  logic              bus_gnt,
    output logic              busy,
    output logic              done,
    output logic              err_overrun,
    output logic              err_range,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              pop,
    output logic              load,
    output logic              clear
);

    localparam logic [ADDR_W:0]  SPAN    = (ADDR_W+1)'(1) << ADDR_W;
    localparam logic [CNT_W-1:0] BURST_N = CNT_W'(BURST);

    dma_state_e        state;
    dma_state_e        state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  words_left;
    logic [LEN_W-1:0]  words_init;
    logic [LEN_W:0]    len_plus;
    logic [CNT_W-1:0]  beats;
    logic [ADDR_W:0]   end_sum;
    logic              range_bad;
    logic              accept;
    logic              accept_ok;
    logic              thresh_hit;
    logic              flush_ready;

    always_comb begin
        end_sum     = {1'b0, cfg_addr} + (ADDR_W+1)'(cfg_len);
        range_bad   = (end_sum > SPAN);
        accept      = start && (state == ST_IDLE);
        accept_ok   = accept && !range_bad;
        len_plus    = {1'b0, cfg_len} + (LEN_W+1)'(1);
        words_init  = len_plus[LEN_W:1];
        thresh_hit  = (fifo_count >= BURST_N);
        flush_ready = in_done && (fifo_count != '0);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept_ok) state_nx = ST_FILL;
            end
            ST_FILL: begin
                if (overrun)                        state_nx = ST_IDLE;
                else if (words_left == '0)          state_nx = ST_IDLE;
                else if (thresh_hit || flush_ready) state_nx = ST_REQ;
            end
            ST_REQ: begin
                if (overrun)      state_nx = ST_IDLE;
                else if (bus_gnt) state_nx = ST_BURST;
            end
            ST_BURST: begin
                if (overrun)                    state_nx = ST_IDLE;
                else if (beats == CNT_W'(1))    state_nx = ST_FILL;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        bus_req  = (state == ST_REQ) || (state == ST_BURST);
        bus_wr   = (state == ST_BURST);
        pop      = bus_wr;
        load     = accept_ok;
        clear    = overrun && busy;
        bus_addr = addr_q;
    end

    // Counters and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            words_left  <= '0;
            beats       <= '0;
            done        <= 1'b0;
            err_overrun <= 1'b0;
            err_range   <= 1'b0;
        end else begin
            if (accept) begin
                done        <= 1'b0;
                err_overrun <= 1'b0;
                err_range   <= range_bad;
            end
            if (accept_ok) begin
                addr_q     <= cfg_addr;
                words_left <= words_init;
            end
            if (state == ST_REQ && bus_gnt) begin
                beats <= thresh_hit ? BURST_N : fifo_count;
            end
            if (state == ST_BURST) begin
                addr_q     <= addr_q + ADDR_W'(2);
                words_left <= words_left - LEN_W'(1);
                beats      <= beats - CNT_W'(1);
            end
            if (state == ST_FILL && words_left == '0 && !overrun) begin
                done <= 1'b1;
            end
            if (clear) begin
                err_overrun <= 1'b1;
            end
        end
    end

    // R3
    req_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (fifo_count >= BURST_N || in_done));

    // R4
    burst_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && $past(bus_wr)) |-> (bus_addr == $past(bus_addr) + ADDR_W'(2)));

    // R4
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && beats == CNT_W'(1)) |=> !bus_req);

    // R5
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R5
    write_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_gnt);

    // R7
    overrun_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> !busy);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);

    // R10
    busy_start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !bus_wr) |=> $stable(bus_addr));

endmodule

// File: rtl/burst_dma_engine.sv
module burst_dma_engine #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 64,
    parameter int BURST_LEN  = 32,
    parameter int GRACE      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic              busy,
    output logic              done,
    output logic              err_overrun,
    output logic              err_range,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              src_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic             f_push;
    logic [15:0]      f_wdata;
    logic             f_pop;
    logic [CNT_W-1:0] f_count;
    logic             f_full;
    logic             in_done;
    logic             overrun;
    logic             load;
    logic             clear;

    dma_byte_packer #(
        .LEN_W (LEN_W),
        .GRACE (GRACE)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .load      (load),
        .load_len  (cfg_len),
        .active    (busy),
        .in_valid  (src_valid),
        .in_data   (src_data),
        .fifo_full (f_full),
        .in_ready  (src_ready),
        .push      (f_push),
        .push_word (f_wdata),
        .in_done   (in_done),
        .overrun   (overrun)
    );

    dma_word_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (16)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .rdata (bus_wdata),
        .count (f_count),
        .full  (f_full)
    );

    dma_burst_ctrl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .BURST  (BURST_LEN),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cfg_start),
        .cfg_addr    (cfg_addr),
        .cfg_len     (cfg_len),
        .fifo_count  (f_count),
        .in_done     (in_done),
        .overrun     (overrun),
        .bus_gnt     (bus_gnt),
        .busy        (busy),
        .done        (done),
        .err_overrun (err_overrun),
        .err_range   (err_range),
        .bus_req     (bus_req),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .pop         (f_pop),
        .load        (load),
        .clear       (clear)
    );

endmodule

// File: tb/test_burst_dma_engine.sv
module test_burst_dma_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_start;
    logic [23:0] cfg_addr;
    logic [15:0] cfg_len;
    logic        busy, done, err_overrun, err_range;
    logic        src_valid;
    logic [7:0]  src_data;
    logic        src_ready;
    logic        bus_req;
    logic        bus_gnt;
    logic        bus_wr;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;

    int checks = 0;
    int fails = 0;

    int          exp_len = 0;
    int          exp_words = 0;
    logic [23:0] exp_base = '0;
    int          seed_g = 0;
    int          wr_idx = 0;
    int          run_len = 0;
    bit          mon_en = 1'b0;
    int          gnt_delay = 0;
    int          wait_cnt = 0;

    always #5 clk = ~clk;

    burst_dma_engine i_burst_dma_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_start   (cfg_start),
        .cfg_addr    (cfg_addr),
        .cfg_len     (cfg_len),
        .busy        (busy),
        .done        (done),
        .err_overrun (err_overrun),
        .err_range   (err_range),
        .src_valid   (src_valid),
        .src_data    (src_data),
        .src_ready   (src_ready),
        .bus_req     (bus_req),
        .bus_gnt     (bus_gnt),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input int i, input int s);
        return 8'((i * 37 + s * 11 + 5) & 255);
    endfunction

    function automatic logic [15:0] word_at(input int k);
        logic [7:0] lo, hi;
        lo = byte_at(2 * k, seed_g);
        hi = (2 * k + 1 < exp_len) ? byte_at(2 * k + 1, seed_g) : 8'h00;
        return {hi, lo};
    endfunction

    function automatic int len_at(input int j);
        case (j)
            0: return 1;    1: return 2;    2: return 3;    3: return 4;
            4: return 31;   5: return 63;   6: return 64;   7: return 65;
            8: return 66;   9: return 127;  10: return 128; 11: return 129;
            12: return 130; default: return 200;
        endcase
    endfunction

    // Bus responder: grants after gnt_delay cycles of request
    initial begin
        bus_gnt = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (!bus_req) begin
                bus_gnt  = 1'b0;
                wait_cnt = 0;
            end else if (!bus_gnt) begin
                if (wait_cnt >= gnt_delay) bus_gnt = 1'b1;
                else wait_cnt++;
            end
        end
    end

    // Write monitor
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (!busy && bus_req) chk(1'b0, "R5", "request while idle", 1, 0);
            if (bus_wr) begin
                chk(bus_gnt == 1'b1, "R5", "write without grant", int'(bus_gnt), 1);
                chk(bus_addr == exp_base + 24'(2 * wr_idx), "R4", "write address",
                    int'(bus_addr), int'(exp_base + 24'(2 * wr_idx)));
                chk(bus_wdata == word_at(wr_idx), "R2", "packed word",
                    int'(bus_wdata), int'(word_at(wr_idx)));
                wr_idx++;
                run_len++;
            end else if (run_len > 0) begin
                chk(run_len == 32 || wr_idx == exp_words, "R4", "burst length", run_len, 32);
                chk(bus_req == 1'b0, "R4", "release after burst", int'(bus_req), 0);
                run_len = 0;
            end
        end
    end

    task automatic send_bytes(input int n, input int gap, output int got);
        got = 0;
        for (int i = 0; i < n; i++) begin
            logic rdy;
            logic bsy;
            rdy = 1'b0;
            src_valid = 1'b1;
            src_data  = byte_at(i, seed_g);
            forever begin
                @(negedge clk);
                rdy = src_ready;
                bsy = busy;
                @(posedge clk);
                #1;
                if (rdy || !bsy) break;
            end
            src_valid = 1'b0;
            if (!rdy) return;
            got++;
            for (int g = 0; g < gap; g++) begin
                @(posedge clk);
                #1;
            end
        end
    endtask

    task automatic pulse_start(input logic [23:0] a, input logic [15:0] l);
        cfg_addr  = a;
        cfg_len   = l;
        cfg_start = 1'b1;
        @(posedge clk);
        #1;
        cfg_start = 1'b0;
    endtask

    task automatic run_transfer(input logic [23:0] a, input int len, input int seed,
                                input int gap, input int gdly, input bit poke);
        int got;
        exp_base  = a;
        exp_len   = len;
        exp_words = (len + 1) / 2;
        seed_g    = seed;
        wr_idx    = 0;
        run_len   = 0;
        gnt_delay = gdly;
        mon_en    = 1'b1;
        pulse_start(a, 16'(len));
        @(negedge clk);
        // R11: accepted start clears all status
        chk(busy && !done && !err_overrun && !err_range, "R11", "status after start",
            int'({busy, done, err_overrun, err_range}), 8);
        @(posedge clk);
        #1;
        fork
            send_bytes(len, gap, got);
            begin
                if (poke) begin
                    repeat (30) @(posedge clk);
                    #1;
                    // R10: out-of-range start while busy must be ignored
                    pulse_start(24'hFFFFF0, 16'hFFFF);
                end
            end
        join
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(got == len, "R6", "bytes accepted", got, len);
        chk(done == 1'b1, "R9", "done raised", int'(done), 1);
        chk(busy == 1'b0, "R9", "busy dropped", int'(busy), 0);
        chk(wr_idx == exp_words, "R9", "words written", wr_idx, exp_words);
        chk(err_range == 1'b0, poke ? "R10" : "R8", "no range error", int'(err_range), 0);
        chk(err_overrun == 1'b0, "R7", "no overrun", int'(err_overrun), 0);
        mon_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int got;
        rst_n     = 1'b0;
        cfg_start = 1'b0;
        cfg_addr  = '0;
        cfg_len   = '0;
        src_valid = 1'b1;
        src_data  = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk({busy, done, err_overrun, err_range, bus_req, bus_wr, src_ready} == 7'b0,
            "R1", "outputs in reset",
            int'({busy, done, err_overrun, err_range, bus_req, bus_wr, src_ready}), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, err_overrun, err_range, bus_req, bus_wr, src_ready} == 7'b0,
            "R1", "outputs after reset",
            int'({busy, done, err_overrun, err_range, bus_req, bus_wr, src_ready}), 0);
        @(posedge clk);
        #1;
        src_valid = 1'b0;

        // Sweep lengths x source gaps x grant delays (R2, R3, R4, R5, R6, R9)
        for (int j = 0; j < 14; j++) begin
            for (int g = 0; g < 3; g++) begin
                for (int d = 0; d < 3; d++) begin
                    int gap;
                    int dly;
                    gap = (g == 2) ? 3 : g;
                    dly = (d == 0) ? 0 : ((d == 1) ? 2 : 7);
                    run_transfer(24'h010000 + 24'(j * 4096) + 24'(g * 64 + d * 8),
                                 len_at(j), j * 9 + g * 3 + d, gap, dly,
                                 (j == 13 && d == 1));
                end
            end
        end

        // R8: one byte past the top of the space is rejected
        pulse_start(24'hFFFF00, 16'h0101);
        @(negedge clk);
        chk(err_range == 1'b1, "R8", "range rejected", int'(err_range), 1);
        chk(busy == 1'b0 && bus_req == 1'b0, "R8", "no transfer begun",
            int'({busy, bus_req}), 0);
        @(posedge clk);
        #1;
        // R8: ending exactly at the top is accepted (and R11 clears err_range)
        run_transfer(24'hFFFF00, 256, 77, 0, 1, 1'b0);

        // R7: never grant, fill buffer, then stall 7 then 8 cycles
        gnt_delay = 1000000;
        seed_g    = 3;
        exp_len   = 300;
        pulse_start(24'h002000, 16'd300);
        send_bytes(128, 0, got);
        chk(got == 128, "R6", "bytes taken without bus ownership", got, 128);
        @(negedge clk);
        chk(src_ready == 1'b0, "R6", "ready low when buffer full", int'(src_ready), 0);
        @(posedge clk);
        #1;
        src_valid = 1'b1;
        repeat (7) @(posedge clk);
        #1;
        src_valid = 1'b0;
        @(negedge clk);
        chk(err_overrun == 1'b0 && busy == 1'b1, "R7", "7-cycle stall tolerated",
            int'({err_overrun, busy}), 1);
        @(posedge clk);
        #1;
        src_valid = 1'b1;
        repeat (8) @(posedge clk);
        #1;
        src_valid = 1'b0;
        @(negedge clk);
        chk(err_overrun == 1'b1, "R7", "overrun flagged", int'(err_overrun), 1);
        chk(busy == 1'b0 && bus_req == 1'b0, "R7", "transfer abandoned",
            int'({busy, bus_req}), 0);
        @(posedge clk);
        #1;

        // R11: retry after overrun clears the flag and completes
        run_transfer(24'h002000, 65, 3, 0, 0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule